// File: doc/BRIEF.md
# Correlating Branch Predictor with Target Buffer

This block sits in the fetch stage and guesses, from the fetch address alone and before any decode, whether the instruction at that address is a taken branch and where it goes. A tagged target buffer recognises addresses that have resolved as branches before and holds their last target. An untagged table of 2-bit saturating counters gives the direction. The counter table is indexed by low word-address bits joined with a short global record of recent branch outcomes. With a two-bit record, each address slot owns four counters, and the recent global pattern picks one of them.

A lookup presented with `fetch_valid` produces a registered prediction one cycle later. The prediction carries the global history value that chose the counter. When the branch resolves, the execution side returns that history on the update port together with the branch address, the actual outcome and the actual target. The update then trains exactly that counter, shifts the outcome into the global history and rewrites the target buffer entry. Setting the history length to zero turns the direction table into a plain per-address table of 2-bit counters.

Top module: `corr_branch_pred`

## Requirements
- R1: After reset `pred_valid`, `pred_hit`, `pred_taken`, `pred_target` and `pred_hist` are zero, every direction counter holds 01 (weakly not-taken), the global history is zero, and no target buffer entry is valid.
- R2: A lookup with `fetch_valid` high at a clock edge gives its result on the outputs after that edge, with `pred_valid` high for that one cycle. `pred_valid` is low in a cycle after an edge where `fetch_valid` was low.
- R3: The target buffer has 2^BTB_IW entries indexed by PC bits [BTB_IW+1:2] and tagged by bits [PC_W-1:BTB_IW+2]. A lookup is a hit only if the entry is valid and its tag equals the fetch tag. On a miss the outputs are `pred_hit`=0, `pred_taken`=0 and `pred_target`=fetch PC+4.
- R4: Every update writes the entry at the index of `upd_pc`: it sets the entry valid, stores the tag of `upd_pc`, and stores `upd_target`, whether the branch was taken or not.
- R5: On a hit, `pred_taken` is bit 1 of the selected counter, and `pred_target` is the stored target when taken, otherwise PC+4. A counter counts up on a taken update and down on a not-taken update, saturating at 00 and 11, so a counter in a strong state needs two opposite outcomes to change its prediction.
- R6: The counter index is {PC[PHT_AW+1:2], history}. A lookup uses the current global history, and an update uses `upd_hist`. The table has no tags, so addresses with equal index bits share counters.
- R7: Each update shifts `upd_taken` into bit 0 of the global history and drops the oldest bit. The history is unchanged in cycles without an update. `pred_hist` reports the history that the lookup used.
- R8: An update changes only the one counter that it selects. All other counters keep their values.
- R9: When a lookup and an update happen at the same edge, the lookup sees the table, target buffer and history as they were before that update.
- R10: With HIST_W=0 the counter index is PC[PHT_AW+1:2] alone, `upd_hist` is ignored, and `pred_hist` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request |
| fetch_pc | input | PC_W | Fetch address to predict |
| upd_valid | input | 1 | Resolved-branch update |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | max(HIST_W,1) | History value returned with the prediction |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | PC_W | Actual taken target |
| pred_valid | output | 1 | Prediction present on the outputs |
| pred_hit | output | 1 | Target buffer tag matched |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | PC_W | Predicted next fetch address |
| pred_hist | output | max(HIST_W,1) | Global history used for this prediction |

## Verification
The hardest case to reach is a single address that trains several counters under different history values while other addresses alias onto the same counters, with updates falling in the same cycle as lookups of the same address. The random phase draws addresses from a small pool, so tags collide in the target buffer and index bits collide in the counter table. It also returns random history values on the update port, so every counter of a slot gets trained. Directed sequences drive counters to saturation and back, and they issue a lookup and an update together to check that the lookup sees the state from before the update. A second instance with no history runs the same stimulus to show that the design reduces to a per-address table.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_train(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int PC_W = 32,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic [PC_W-1:0] up_target,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target
);
  localparam int N     = 1 << IW;
  localparam int TAG_W = PC_W - IW - 2;

  logic             vld [N];
  logic [TAG_W-1:0] tag_mem [N];
  logic [PC_W-1:0]  tgt_mem [N];

  logic [IW-1:0] lk_idx, up_idx;
  assign lk_idx = lk_pc[IW+1:2];
  assign up_idx = up_pc[IW+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) vld[i] <= 1'b0;
    end else if (up_en) begin
      vld[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (up_en) begin
      tag_mem[up_idx] <= up_pc[PC_W-1:IW+2];
      tgt_mem[up_idx] <= up_target;
    end
  end

  assign lk_hit    = vld[lk_idx] && (tag_mem[lk_idx] == lk_pc[PC_W-1:IW+2]);
  assign lk_target = tgt_mem[lk_idx];
endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int HIST_W = 2,
  parameter int HPW    = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_slot,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_slot,
  input  logic [HPW-1:0]    up_hist,
  input  logic              up_taken,
  output logic              lk_dir,
  output logic [HPW-1:0]    hist_now
);
  localparam int IDX_W = ADDR_W + HIST_W;
  localparam int DEPTH = 1 << IDX_W;

  ctr_t             tbl [DEPTH];
  logic [IDX_W-1:0] lk_idx, up_idx;

  generate
    if (HIST_W > 0) begin : g_hist
      logic [HIST_W-1:0] ghr;
      always_ff @(posedge clk) begin
        if (rst)        ghr <= '0;
        else if (up_en) ghr <= HIST_W'({ghr, up_taken});
      end
      assign lk_idx   = {lk_slot, ghr};
      assign up_idx   = {up_slot, up_hist[HIST_W-1:0]};
      assign hist_now = ghr;
    end else begin : g_nohist
      logic unused_hist;
      assign unused_hist = ^{up_hist, up_taken};
      assign lk_idx   = lk_slot;
      assign up_idx   = up_slot;
      assign hist_now = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_RESET;
    end else if (up_en) begin
      tbl[up_idx] <= ctr_train(tbl[up_idx], up_taken);
    end
  end

  assign lk_dir = tbl[lk_idx][1];
endmodule

// File: rtl/corr_branch_pred.sv
module corr_branch_pred #(
  parameter int PC_W   = 32,
  parameter int BTB_IW = 4,
  parameter int PHT_AW = 4,
  parameter int HIST_W = 2,
  parameter int HPW    = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [HPW-1:0]  upd_hist,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic [HPW-1:0]  pred_hist
);
  logic            btb_hit;
  logic [PC_W-1:0] btb_tgt;
  logic            dir;
  logic [HPW-1:0]  hist_now;
  logic            unused_lo;
  assign unused_lo = ^upd_pc[1:0];

  bp_btb #(.PC_W(PC_W), .IW(BTB_IW)) u_btb (
    .clk(clk), .rst(rst),
    .lk_pc(fetch_pc),
    .up_en(upd_valid), .up_pc(upd_pc), .up_target(upd_target),
    .lk_hit(btb_hit), .lk_target(btb_tgt)
  );

  bp_pht #(.ADDR_W(PHT_AW), .HIST_W(HIST_W), .HPW(HPW)) u_pht (
    .clk(clk), .rst(rst),
    .lk_slot(fetch_pc[PHT_AW+1:2]),
    .up_en(upd_valid), .up_slot(upd_pc[PHT_AW+1:2]),
    .up_hist(upd_hist), .up_taken(upd_taken),
    .lk_dir(dir), .hist_now(hist_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_taken  <= 1'b0;
      pred_target <= '0;
      pred_hist   <= '0;
    end else begin
      pred_valid <= fetch_valid;
      if (fetch_valid) begin
        pred_hit    <= btb_hit;
        pred_taken  <= btb_hit & dir;
        pred_target <= (btb_hit & dir) ? btb_tgt : fetch_pc + PC_W'(4);
        pred_hist   <= hist_now;
      end
    end
  end
endmodule

// File: rtl/bp_chk.sv
module bp_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2,
  parameter int HPW    = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic            pred_valid,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic [HPW-1:0]  hist_now
);
  // R2
  pv_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);
  // R2
  pv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);
  // R3
  fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (pred_taken || pred_target == $past(fetch_pc) + PC_W'(4)));
  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(hist_now));
  generate
    if (HIST_W > 0) begin : g_h
      // R7
      hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> hist_now[0] == $past(upd_taken));
    end
  endgenerate
endmodule

bind corr_branch_pred bp_chk #(.PC_W(PC_W), .HIST_W(HIST_W), .HPW(HPW)) u_chk (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .pred_target(pred_target), .hist_now(hist_now)
);

// File: tb/tb_corr_branch_pred.sv
`timescale 1ns/1ps
module tb_corr_branch_pred;
  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic        fv, uv, ut;
  logic [31:0] fpc, upc, utgt;
  logic [1:0]  uh;
  logic        pv0, ph0, pt0, pv1, ph1, pt1;
  logic [31:0] ptg0, ptg1;
  logic [1:0]  phs0;
  logic        phs1;

  corr_branch_pred dut (
    .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_pc(fpc),
    .upd_valid(uv), .upd_pc(upc), .upd_hist(uh), .upd_taken(ut), .upd_target(utgt),
    .pred_valid(pv0), .pred_hit(ph0), .pred_taken(pt0), .pred_target(ptg0), .pred_hist(phs0));

  corr_branch_pred #(.HIST_W(0)) dut_h0 (
    .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_pc(fpc),
    .upd_valid(uv), .upd_pc(upc), .upd_hist(1'b0), .upd_taken(ut), .upd_target(utgt),
    .pred_valid(pv1), .pred_hit(ph1), .pred_taken(pt1), .pred_target(ptg1), .pred_hist(phs1));

  int total = 0, bad = 0;
  bit done = 0;

  // reference state: counters for model 0 (2-bit history) and model 1 (none)
  logic [1:0]  m_ctr0 [64];
  logic [1:0]  m_ctr1 [16];
  logic [1:0]  m_ghr;
  logic        m_bv   [16];
  logic [25:0] m_btag [16];
  logic [31:0] m_btgt [16];

  function automatic logic [1:0] train(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic f, logic [31:0] fp, logic u, logic [31:0] up,
                      logic [1:0] h, logic t, logic [31:0] tg);
    logic        hit, d0, d1;
    logic [31:0] e_t0, e_t1;
    logic [1:0]  e_h;
    fv = f; fpc = fp; uv = u; upc = up; uh = h; ut = t; utgt = tg;
    hit  = m_bv[fp[5:2]] && m_btag[fp[5:2]] == fp[31:6];
    d0   = hit && m_ctr0[{fp[5:2], m_ghr}][1];
    d1   = hit && m_ctr1[fp[5:2]][1];
    e_t0 = d0 ? m_btgt[fp[5:2]] : fp + 32'd4;
    e_t1 = d1 ? m_btgt[fp[5:2]] : fp + 32'd4;
    e_h  = m_ghr;
    if (u) begin
      m_ctr0[{up[5:2], h}] = train(m_ctr0[{up[5:2], h}], t);
      m_ctr1[up[5:2]]      = train(m_ctr1[up[5:2]], t);
      m_ghr                = {m_ghr[0], t};
      m_bv[up[5:2]]   = 1'b1;
      m_btag[up[5:2]] = up[31:6];
      m_btgt[up[5:2]] = tg;
    end
    @(negedge clk);
    chk("R2", "pred_valid", {31'd0, pv0}, {31'd0, f});
    if (f) begin
      chk(req, "hit",    {31'd0, ph0}, {31'd0, hit});
      chk(req, "taken",  {31'd0, pt0}, {31'd0, d0});
      chk(req, "target", ptg0, e_t0);
      chk(req, "hist",   {30'd0, phs0}, {30'd0, e_h});
      chk("R10", "h0 taken",  {31'd0, pt1}, {31'd0, d1});
      chk("R10", "h0 target", ptg1, e_t1);
      chk("R10", "h0 hist",   {31'd0, phs1}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    fv = 0; uv = 0; ut = 0; fpc = 0; upc = 0; uh = 0; utgt = 0;
    for (int i = 0; i < 64; i++) m_ctr0[i] = 2'b01;
    for (int i = 0; i < 16; i++) begin m_ctr1[i] = 2'b01; m_bv[i] = 0; m_btag[i] = 0; m_btgt[i] = 0; end
    m_ghr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pred_valid", {31'd0, pv0}, 32'd0);
    chk("R1", "pred_target", ptg0, 32'd0);
    chk("R1", "pred_hist", {30'd0, phs0}, 32'd0);
    step("R1", 1, 32'h100, 0, 0, 0, 0, 0);
    step("R2", 0, 32'h0, 0, 0, 0, 0, 0);
    // R4: allocate 0x40 not-taken; hit with fall-through target
    step("R4", 0, 0, 1, 32'h40, 2'b00, 0, 32'h800);
    step("R4", 1, 32'h40, 0, 0, 0, 0, 0);
    // R3: same index, other tag misses
    step("R3", 1, 32'h440, 0, 0, 0, 0, 0);
    // R5: saturate counter {slot0,hist 00} up, then two downs to flip
    for (int k = 0; k < 3; k++) step("R5", 0, 0, 1, 32'h40, 2'b00, 1, 32'h800);
    step("R6", 1, 32'h40, 0, 0, 0, 0, 0);
    for (int k = 0; k < 2; k++) step("R5", 0, 0, 1, 32'h40, 2'b00, 0, 32'h800);
    step("R5", 1, 32'h40, 0, 0, 0, 0, 0);
    // R9: lookup and update of the same address in one cycle
    step("R9", 1, 32'h80, 1, 32'h80, m_ghr, 1, 32'h900);
    step("R9", 1, 32'h80, 1, 32'h80, m_ghr, 1, 32'h900);
    step("R9", 1, 32'h80, 0, 0, 0, 0, 0);
    // R7: history shifts
    step("R7", 0, 0, 1, 32'h4, 0, 1, 32'h10);
    step("R7", 0, 0, 1, 32'h4, 0, 0, 32'h10);
    step("R7", 1, 32'h8, 0, 0, 0, 0, 0);
    // R6 R8 random phase with aliasing addresses
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b;
      a = ($urandom % 128) << 2;
      b = ($urandom % 128) << 2;
      step("R8", ($urandom % 4) != 0, a, ($urandom % 3) != 0, b,
           2'($urandom % 4), 1'($urandom % 2), ($urandom % 1024) << 2);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule